// File: doc/BRIEF.md
# TPDF Dithered Word-Length Reducer

This block shortens a stream of signed two's-complement samples to a narrower signed word. With the default parameters it takes 16-bit samples down to 8 bits. Before the low bits are dropped, a pseudo-random dither with a triangular probability density is added to each sample. This makes the requantisation error independent of the signal, so that over many samples the average output follows the input, even for inputs that lie between two output levels.

The dither is the sum of two uniform values. Each value is one output LSB wide and comes from its own free-running Galois LFSR; the two LFSRs use different feedback taps. The dithered sum is rounded to the nearest output level in a widened datapath. A result outside the output range is clamped to the extreme code instead of wrapping. A sample is accepted when `in_valid` is high, and its result appears on the next clock with `out_valid`. The LFSRs step only on accepted samples. A synchronous reset reloads their seeds, so the dither sequence is repeatable.

Top module: `tpdf_requant`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` was high and reset was low, and is low after every cycle in which `in_valid` was low.
- R2: Let S = IN_W−OUT_W. For an accepted input x, the output code lies between floor((x − (2^S−1) + 2^(S−1)) / 2^S) and floor((x + (2^S−1) + 2^(S−1)) / 2^S), after clamping. For an input that sits exactly on an output level k·2^S, the output is k−1, k or k+1.
- R3: Outputs are two's complement. An accepted result above 2^(OUT_W−1)−1 becomes exactly that code (127 by default). A result below −2^(OUT_W−1) becomes exactly that code (−128 by default). Results never wrap in sign.
- R4: While reset is applied and afterwards, until the first accepted sample, `out_valid` is 0 and `out_sample` is 0.
- R5: After each synchronous reset, the same input sequence produces the same output sequence. The internal LFSR states are never all-zero.
- R6: The dither generators advance only on accepted samples. Idle cycles between samples leave the output sequence for a given input sequence unchanged.
- R7: With a fixed input x, the mean of the output codes over 2000 samples is x/2^S to within 0.06 output LSB. This includes inputs at a quarter and a half of an output LSB.
- R8: While `in_valid` is low, `out_sample` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; reloads the LFSR seeds |
| in_valid | input | 1 | Sample strobe; the sample is accepted when high |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | High one cycle after an accepted sample |
| out_sample | output | OUT_W | Signed reduced-width sample |

## Verification
The bench uses the default parameters: a 16-bit input, an 8-bit output (a shift of 8) and two 16-bit LFSRs. With these values the dither spans ±255 input units. This range reaches both the positive and the negative saturation codes, and it allows inputs at exactly a quarter and a half of an output LSB. The narrow 8-bit output keeps the extremes easy to reach with directed inputs. The 2000-sample averages then resolve a bias of well under a tenth of an output LSB. Two runs are compared after reset, one with idle gaps and one without, to show that the dither sequence depends only on the accepted samples.

// File: rtl/tpdf_pkg.sv
package tpdf_pkg;
    // Default Galois feedback masks for the two dither generators
    localparam logic [31:0] DEF_TAPS_A = 32'h0000_B400;
    localparam logic [31:0] DEF_TAPS_B = 32'h0000_D008;
    // Default nonzero seeds
    localparam logic [31:0] DEF_SEED_A = 32'h0000_ACE1;
    localparam logic [31:0] DEF_SEED_B = 32'h0000_5EED;

    // One right-shifting Galois step on a zero-extended state
    function automatic logic [31:0] galois_step(input logic [31:0] s, input logic [31:0] taps);
        galois_step = s[0] ? ((s >> 1) ^ taps) : (s >> 1);
    endfunction
endpackage

// File: rtl/tpdf_lfsr.sv
module tpdf_lfsr
    import tpdf_pkg::*;
#(
    parameter int          W    = 16,
    parameter logic [31:0] TAPS = DEF_TAPS_A,
    parameter logic [31:0] SEED = DEF_SEED_A
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] state
);
    logic [W-1:0] state_d, state_q;
    logic [31:0]  stepped;

    always_comb begin
        stepped = galois_step(32'(state_q), TAPS);
        state_d = state_q;
        if (rst) begin
            state_d = SEED[W-1:0];
        end else if (adv) begin
            state_d = stepped[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign state = state_q;

    // R5: the generator never locks up in the all-zero state
    a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R6: no step without an accepted sample
    a_r6_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q));
endmodule

// File: rtl/tpdf_dither.sv
module tpdf_dither #(
    parameter int SHIFT = 8
) (
    input  logic [SHIFT-1:0]        ua,
    input  logic [SHIFT-1:0]        ub,
    output logic signed [SHIFT+1:0] dither
);
    // Centre the sum of two uniforms so that it is symmetric about zero
    localparam logic signed [SHIFT+1:0] BIAS = (SHIFT+2)'((2 ** SHIFT) - 1);

    always_comb begin
        dither = $signed({2'b00, ua}) + $signed({2'b00, ub}) - BIAS;
    end
endmodule

// File: rtl/tpdf_quant.sv
module tpdf_quant #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8,
    localparam int SHIFT = IN_W - OUT_W
) (
    input  logic signed [IN_W-1:0]    sample,
    input  logic signed [SHIFT+1:0]   dither,
    output logic        [OUT_W-1:0]   code
);
    localparam int SW = IN_W + 2;
    localparam logic signed [SW-1:0] HALF = SW'(2 ** (SHIFT - 1));
    localparam logic signed [SW-1:0] MAXC = SW'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SW-1:0] MINC = SW'(-(2 ** (OUT_W - 1)));

    logic signed [SW-1:0] sum_w;
    logic signed [SW-1:0] scaled;

    always_comb begin
        sum_w  = SW'(sample) + SW'(dither) + HALF;
        scaled = sum_w >>> SHIFT;
        if (scaled > MAXC) begin
            code = MAXC[OUT_W-1:0];
        end else if (scaled < MINC) begin
            code = MINC[OUT_W-1:0];
        end else begin
            code = scaled[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/tpdf_requant.sv
module tpdf_requant
    import tpdf_pkg::*;
#(
    parameter int          IN_W   = 16,
    parameter int          OUT_W  = 8,
    parameter int          LFSR_W = 16,
    parameter logic [31:0] TAPS_A = DEF_TAPS_A,
    parameter logic [31:0] TAPS_B = DEF_TAPS_B,
    parameter logic [31:0] SEED_A = DEF_SEED_A,
    parameter logic [31:0] SEED_B = DEF_SEED_B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample
);
    localparam int SHIFT = IN_W - OUT_W;
    localparam int MAX_OUT = (2 ** (OUT_W - 1)) - 1;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] sample;
    } out_t;

    out_t r_d, r_q;

    logic [LFSR_W-1:0]        lfsr_a, lfsr_b;
    logic signed [SHIFT+1:0]  dither_w;
    logic [OUT_W-1:0]         code_w;

    tpdf_lfsr #(.W(LFSR_W), .TAPS(TAPS_A), .SEED(SEED_A)) u_lfsr_a (
        .clk(clk), .rst(rst), .adv(in_valid), .state(lfsr_a)
    );

    tpdf_lfsr #(.W(LFSR_W), .TAPS(TAPS_B), .SEED(SEED_B)) u_lfsr_b (
        .clk(clk), .rst(rst), .adv(in_valid), .state(lfsr_b)
    );

    tpdf_dither #(.SHIFT(SHIFT)) u_dither (
        .ua(lfsr_a[SHIFT-1:0]), .ub(lfsr_b[SHIFT-1:0]), .dither(dither_w)
    );

    tpdf_quant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_quant (
        .sample($signed(in_sample)), .dither(dither_w), .code(code_w)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = in_valid;
        if (in_valid) begin
            r_d.sample = code_w;
        end
        if (rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign out_valid  = r_q.valid;
    assign out_sample = r_q.sample;

    // R1: one cycle from strobe in to strobe out
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: reset clears the output register
    a_r4_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    // R8: output word holds while idle
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    // R2: a level-aligned input moves by at most one code
    a_r2_within_one_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample[SHIFT-1:0] == '0) |=>
        ((int'($signed(out_sample)) - int'($signed($past(in_sample[IN_W-1:SHIFT])))) <= 1 &&
         (int'($signed(out_sample)) - int'($signed($past(in_sample[IN_W-1:SHIFT])))) >= -1));

    // R3: no sign wrap at either end, exact clamp at the top
    a_r3_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'($signed(in_sample)) >= (2 ** SHIFT)) |=> !out_sample[OUT_W-1]);
    a_r3_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'($signed(in_sample)) <= -(2 ** (SHIFT + 1))) |=> out_sample[OUT_W-1]);
    a_r3_sat_top: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample == {1'b0, {(IN_W-1){1'b1}}}) |=>
        (int'($signed(out_sample)) == MAX_OUT));
endmodule

// File: tb/tpdf_requant_bench.sv
module tpdf_requant_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 16;
    localparam int OUT_W = 8;
    localparam int SHIFT = IN_W - OUT_W;
    localparam int MAXC  = (2 ** (OUT_W - 1)) - 1;
    localparam int MINC  = -(2 ** (OUT_W - 1));
    localparam int NMEAN = 2000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_sample = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_sample;

    tpdf_requant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_tpdf_requant (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    int    lo_q[$];
    int    hi_q[$];
    string tag_q[$];
    int    log_q[$];
    int    sum_acc = 0;
    int    n_acc   = 0;
    int    last_out = 0;
    bit    finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampc(input int v);
        if (v > MAXC) return MAXC;
        if (v < MINC) return MINC;
        return v;
    endfunction

    // Drive one accepted sample and queue its allowed output range
    task automatic send(input int x, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x[IN_W-1:0];
        lo_q.push_back(clampc((x - (2 ** SHIFT - 1) + 2 ** (SHIFT - 1)) >>> SHIFT));
        hi_q.push_back(clampc((x + (2 ** SHIFT - 1) + 2 ** (SHIFT - 1)) >>> SHIFT));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: samples one time unit after each rising edge
    always begin
        bit exp_v;
        bit was_rst;
        @(posedge clk);
        exp_v   = in_valid;
        was_rst = rst;
        #1;
        if (was_rst) begin
            last_out = 0;
        end else if (!finished) begin
            check(out_valid == exp_v, "R1", int'(out_valid), int'(exp_v));
            if (out_valid) begin
                int v;
                v = int'($signed(out_sample));
                if (lo_q.size() == 0) begin
                    check(1'b0, "R1", v, 0);
                end else begin
                    int lo;
                    int hi;
                    string tg;
                    lo = lo_q.pop_front();
                    hi = hi_q.pop_front();
                    tg = tag_q.pop_front();
                    check(v >= lo && v <= hi, tg, v, (v < lo) ? lo : hi);
                end
                log_q.push_back(v);
                sum_acc += v;
                n_acc++;
                last_out = v;
            end else begin
                check(int'($signed(out_sample)) == last_out, "R8",
                      int'($signed(out_sample)), last_out);
            end
        end
    end

    task automatic mean_test(input int x);
        real m;
        real want;
        real err;
        sum_acc = 0;
        n_acc   = 0;
        for (int i = 0; i < NMEAN; i++) send(x, "R2");
        idle(2);
        m    = real'(sum_acc) / real'(n_acc);
        want = real'(x) / real'(2 ** SHIFT);
        err  = m - want;
        if (err < 0.0) err = -err;
        checks++;
        if (err > 0.06 || n_acc != NMEAN) begin
            fails++;
            $display("FAIL R7: input=%0d actual mean=%f expected=%f count=%0d", x, m, want, n_acc);
        end
    endtask

    initial begin
        int ref_log[$];
        int gap_log[$];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: reset state before any sample
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);
        check(out_sample == '0, "R4", int'($signed(out_sample)), 0);

        // R2 / R3: directed inputs across the range
        send(0, "R2");      send(256, "R2");    send(-256, "R2");
        send(1000, "R2");   send(-1000, "R2");  send(12345, "R2");
        idle(3);
        send(-20000, "R2"); send(127, "R2");    send(128, "R2");
        send(32767, "R3");  send(32700, "R3");  send(-32768, "R3");
        send(-32700, "R3"); send(32767, "R3");
        idle(4);

        // R5: same sequence after reset gives same outputs
        do_reset();
        log_q.delete();
        for (int i = 0; i < 24; i++) send(0, "R2");
        idle(2);
        ref_log = log_q;
        do_reset();
        log_q.delete();
        for (int i = 0; i < 24; i++) send(0, "R2");
        idle(2);
        check(log_q.size() == ref_log.size(), "R5", log_q.size(), ref_log.size());
        for (int i = 0; i < 24 && i < log_q.size(); i++)
            check(log_q[i] == ref_log[i], "R5", log_q[i], ref_log[i]);

        // R6: idle gaps must not advance the dither
        do_reset();
        log_q.delete();
        for (int i = 0; i < 24; i++) begin
            send(0, "R2");
            idle(3);
        end
        idle(1);
        gap_log = log_q;
        check(gap_log.size() == ref_log.size(), "R6", gap_log.size(), ref_log.size());
        for (int i = 0; i < 24 && i < gap_log.size(); i++)
            check(gap_log[i] == ref_log[i], "R6", gap_log[i], ref_log[i]);

        // R7: long-run mean tracks the input, also between levels
        mean_test(0);
        mean_test(64);
        mean_test(128);
        mean_test(-128);
        mean_test(1000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule